// File: doc/BRIEF.md
# Frame Divider Reset Generator

This block produces the periodic reset that realigns the frame-based output timing counter of a genlocked video timing generator. It counts frame-start strobes taken from the reference input and emits a one-cycle reset pulse once every N such frames. N is a 16-bit value that a host loads through a small register write port.

The host first writes a new divide value into a holding register. That value does nothing until the host writes the control register, and this second write commits it. The control write also picks how the divider phase is set. In automatic mode, the first input frame after the commit fires a reset and starts the count. In host mode, the host raises a sync bit during one output frame. The next output frame-start strobe then fires the reset and restarts the count.

A divide value of zero hands control back to the internally derived default. In that case the pulse simply follows the `default_rst_req` input.

Top module: `frame_div_rst_gen`

## Requirements
- R1: An active-low asynchronous reset clears the held divide value, the active divide value, the mode, the sync history and all phase state to zero. Right after reset, `div_rst_pulse` follows `default_rst_req`, and input or output frame strobes produce no pulse.
- R2: A write to address 8'h18 changes only the held divide value. The pulse period in force stays the same until a commit.
- R3: Any write to address 8'h19 commits the held divide value, which becomes the active period N.
- R4: While the active divide value is zero, `div_rst_pulse` equals `default_rst_req` in the same cycle, and frame strobes have no effect.
- R5: A commit with bit 0 of the 19h data low selects automatic mode. The first `in_frame_stb` after that commit pulses `div_rst_pulse` and restarts the count. Every N-th input strobe after that pulses again.
- R6: With N = 1, every input frame strobe produces a pulse.
- R7: A commit with bit 0 high selects host mode, and such a commit does not realign the count. A 0-to-1 change of bit 1 between successive 19h writes, made in host mode, arms a one-shot. The next `out_frame_stb` then pulses `div_rst_pulse` in its own cycle, restarts the count (the following wrap comes N input strobes later) and disarms the one-shot.
- R8: A 19h write whose bit 1 is high while the previous 19h write also had bit 1 high does not arm the one-shot.
- R9: Bits 15:2 of a 19h write are ignored.
- R10: `div_rst_pulse` is high for exactly the cycle of the strobe that caused it, and never in a cycle that has none of `in_frame_stb`, `out_frame_stb` or `default_rst_req`.
- R11: In host mode, an `out_frame_stb` with no armed one-shot produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address (8'h18 holding divide value, 8'h19 control/commit) |
| wr_data | input | 16 | Register write data |
| in_frame_stb | input | 1 | One-cycle frame-start strobe of the reference input |
| out_frame_stb | input | 1 | One-cycle frame-start strobe of the generated output |
| default_rst_req | input | 1 | Reset request from the internal default divider |
| div_rst_pulse | output | 1 | Frame counter reset pulse |

## Verification
The pulse is a combinational function of the current strobe and of registered state. It is therefore due in the same cycle as the strobe that causes it. The bench drives every stimulus just after a falling edge and samples the pulse one time step later, before the next rising edge.

Register writes, arming and counter updates take effect at the rising edge that closes the stimulus cycle. Their effect is always checked through the pulse during a later strobe, never in the cycle of the write. Each vector occupies exactly one clock cycle, so the expected pulse in the table follows from counting strobes since the last commit or host fire.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam logic [ADDR_W-1:0] ADDR_DIV_HOLD = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 8'h19;
  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_SYNC_BIT = 1;

  // Terminal count reached: last frame of the period (>= guards a shrink of N).
  function automatic logic period_end(input logic [DATA_W-1:0] cnt,
                                      input logic [DATA_W-1:0] n);
    return (n != '0) && (cnt >= n - 1'b1);
  endfunction

  function automatic logic [DATA_W-1:0] count_step(input logic [DATA_W-1:0] cnt,
                                                   input logic [DATA_W-1:0] n);
    return period_end(cnt, n) ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/fdr_regs.sv
module fdr_regs
  import fdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] shadow_div,
  output logic [DATA_W-1:0] active_div,
  output logic              host_mode,
  output logic              commit,
  output logic              commit_mode,
  output logic              sync_rise
);
  logic sync_q;
  logic wr_hold;

  assign wr_hold     = wr_en && (wr_addr == ADDR_DIV_HOLD);
  assign commit      = wr_en && (wr_addr == ADDR_CTRL);
  assign commit_mode = wr_data[CTRL_MODE_BIT];
  assign sync_rise   = commit && commit_mode && wr_data[CTRL_SYNC_BIT] && !sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_div <= '0;
      active_div <= '0;
      host_mode  <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      if (wr_hold) shadow_div <= wr_data;
      if (commit) begin
        active_div <= shadow_div;
        host_mode  <= commit_mode;
        sync_q     <= wr_data[CTRL_SYNC_BIT];
      end
    end
  end
endmodule

// File: rtl/fdr_phase.sv
module fdr_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic commit_mode,
  input  logic sync_rise,
  input  logic div_zero,
  input  logic align_fire,
  input  logic host_fire,
  output logic align_pending,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_pending <= 1'b0;
      armed         <= 1'b0;
    end else begin
      if (commit)          align_pending <= !commit_mode;
      else if (align_fire) align_pending <= 1'b0;

      if (sync_rise)                                  armed <= 1'b1;
      else if (host_fire || div_zero)                 armed <= 1'b0;
      else if (commit && !commit_mode)                armed <= 1'b0;
    end
  end
endmodule

// File: rtl/fdr_counter.sv
module fdr_counter
  import fdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic              reload,
  input  logic              div_zero,
  input  logic [DATA_W-1:0] n,
  output logic [DATA_W-1:0] cnt,
  output logic              at_end
);
  assign at_end = period_end(cnt, n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (div_zero || reload) cnt <= '0;
    else if (in_stb)             cnt <= count_step(cnt, n);
  end
endmodule

// File: rtl/frame_div_rst_gen.sv
module frame_div_rst_gen
  import fdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_frame_stb,
  input  logic              out_frame_stb,
  input  logic              default_rst_req,
  output logic              div_rst_pulse
);
  logic [DATA_W-1:0] shadow_div;
  logic [DATA_W-1:0] active_div;
  logic [DATA_W-1:0] cnt;
  logic host_mode, commit, commit_mode, sync_rise;
  logic align_pending, armed, at_end, div_zero;
  logic align_fire, host_fire, wrap_fire;

  fdr_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shadow_div(shadow_div), .active_div(active_div), .host_mode(host_mode),
    .commit(commit), .commit_mode(commit_mode), .sync_rise(sync_rise)
  );

  assign div_zero   = (active_div == '0);
  assign align_fire = !div_zero && !host_mode && align_pending && in_frame_stb;
  assign host_fire  = !div_zero && host_mode && armed && out_frame_stb;
  assign wrap_fire  = !div_zero && in_frame_stb && at_end;

  fdr_phase phase_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_mode(commit_mode),
    .sync_rise(sync_rise), .div_zero(div_zero), .align_fire(align_fire),
    .host_fire(host_fire), .align_pending(align_pending), .armed(armed)
  );

  fdr_counter counter_i (
    .clk(clk), .rst_n(rst_n), .in_stb(in_frame_stb),
    .reload(align_fire || host_fire), .div_zero(div_zero),
    .n(active_div), .cnt(cnt), .at_end(at_end)
  );

  assign div_rst_pulse = div_zero ? default_rst_req
                                  : (align_fire || host_fire || wrap_fire);
endmodule

// File: rtl/fdr_checker.sv
module fdr_checker
  import fdr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              in_frame_stb,
  input logic              out_frame_stb,
  input logic              default_rst_req,
  input logic              div_rst_pulse,
  input logic [DATA_W-1:0] shadow_div,
  input logic [DATA_W-1:0] active_div,
  input logic [DATA_W-1:0] cnt,
  input logic              armed,
  input logic              host_fire
);
  // R3
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_CTRL) |=> (active_div == $past(shadow_div)));

  // R2
  hold_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_DIV_HOLD) |=> $stable(active_div));

  // R10
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst_pulse |-> (in_frame_stb || out_frame_stb || default_rst_req));

  // R7
  host_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_fire |=> ((cnt == '0) && !armed));

  // R4
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div == '0) |=> (cnt == '0));
endmodule

bind frame_div_rst_gen fdr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .in_frame_stb(in_frame_stb), .out_frame_stb(out_frame_stb),
  .default_rst_req(default_rst_req), .div_rst_pulse(div_rst_pulse),
  .shadow_div(shadow_div), .active_div(active_div), .cnt(cnt),
  .armed(armed), .host_fire(host_fire)
);

// File: tb/frame_div_rst_gen_tb_top.sv
module frame_div_rst_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_W18 = 3'd0, OP_W19 = 3'd1, OP_INF = 3'd2,
                         OP_OUTF = 3'd3, OP_DEF = 3'd4, OP_IDLE = 3'd5;
  localparam int NV = 37;
  // {op[2:0], data[15:0], expected pulse, requirement number[3:0]}
  localparam logic [23:0] VEC [NV] = '{
    {OP_W18, 16'h0003, 1'b0, 4'd2},   // R2 hold only
    {OP_INF, 16'h0000, 1'b0, 4'd2},   // R2 / R4 still zero period
    {OP_W19, 16'h0000, 1'b0, 4'd3},   // R3 commit N=3 auto
    {OP_INF, 16'h0000, 1'b1, 4'd5},   // R5 align on first input frame
    {OP_INF, 16'h0000, 1'b0, 4'd5},
    {OP_INF, 16'h0000, 1'b0, 4'd5},
    {OP_INF, 16'h0000, 1'b1, 4'd5},   // R5 wrap after 3
    {OP_W18, 16'h0002, 1'b0, 4'd2},
    {OP_INF, 16'h0000, 1'b0, 4'd2},   // R2 old period still in force
    {OP_INF, 16'h0000, 1'b0, 4'd2},
    {OP_INF, 16'h0000, 1'b1, 4'd2},
    {OP_W19, 16'h0001, 1'b0, 4'd7},   // R7 host mode N=2, no realign
    {OP_INF, 16'h0000, 1'b0, 4'd7},
    {OP_INF, 16'h0000, 1'b1, 4'd7},
    {OP_OUTF,16'h0000, 1'b0, 4'd11},  // R11 not armed
    {OP_W19, 16'h0003, 1'b0, 4'd7},   // arm
    {OP_INF, 16'h0000, 1'b0, 4'd7},
    {OP_OUTF,16'h0000, 1'b1, 4'd7},   // R7 host fire
    {OP_INF, 16'h0000, 1'b0, 4'd7},
    {OP_INF, 16'h0000, 1'b1, 4'd7},   // R7 wrap N frames after fire
    {OP_W19, 16'h0003, 1'b0, 4'd8},   // R8 sync stays high
    {OP_OUTF,16'h0000, 1'b0, 4'd8},
    {OP_W19, 16'h0001, 1'b0, 4'd7},
    {OP_W19, 16'h0003, 1'b0, 4'd7},
    {OP_OUTF,16'h0000, 1'b1, 4'd7},
    {OP_W19, 16'hFFFC, 1'b0, 4'd9},   // R9 reserved set, auto mode
    {OP_INF, 16'h0000, 1'b1, 4'd9},
    {OP_INF, 16'h0000, 1'b0, 4'd9},
    {OP_INF, 16'h0000, 1'b1, 4'd9},
    {OP_W18, 16'h0001, 1'b0, 4'd6},
    {OP_W19, 16'h0000, 1'b0, 4'd6},
    {OP_INF, 16'h0000, 1'b1, 4'd6},   // R6
    {OP_INF, 16'h0000, 1'b1, 4'd6},
    {OP_W18, 16'h0000, 1'b0, 4'd4},
    {OP_W19, 16'h0000, 1'b0, 4'd4},
    {OP_INF, 16'h0000, 1'b0, 4'd4},   // R4 strobe ignored
    {OP_DEF, 16'h0000, 1'b1, 4'd4}    // R4 passthrough
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic in_frame_stb = 1'b0, out_frame_stb = 1'b0, default_rst_req = 1'b0;
  logic div_rst_pulse;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_div_rst_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_frame_stb(in_frame_stb), .out_frame_stb(out_frame_stb),
    .default_rst_req(default_rst_req), .div_rst_pulse(div_rst_pulse)
  );

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (div_rst_pulse !== exp) begin
      errors++;
      $display("FAIL R%0d %s: div_rst_pulse=%b expected=%b", req, what, div_rst_pulse, exp);
    end
  endtask

  // Drive one operation for one cycle, sample the pulse before the rising edge.
  task automatic do_op(input logic [2:0] op, input logic [15:0] d,
                       input logic exp, input int req, input string what);
    @(negedge clk);
    wr_en = (op == OP_W18) || (op == OP_W19);
    wr_addr = (op == OP_W19) ? 8'h19 : 8'h18;
    wr_data = d;
    in_frame_stb = (op == OP_INF);
    out_frame_stb = (op == OP_OUTF);
    default_rst_req = (op == OP_DEF);
    #1 check(exp, req, what);
    @(posedge clk);
    #1;
    wr_en = 1'b0; in_frame_stb = 1'b0; out_frame_stb = 1'b0; default_rst_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1'b0, 1, "pulse low in reset");
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state: zero period, default passthrough, strobes ignored
    do_op(OP_DEF, 16'h0, 1'b1, 1, "default passthrough after reset");
    do_op(OP_INF, 16'h0, 1'b0, 1, "input strobe after reset");
    do_op(OP_OUTF, 16'h0, 1'b0, 1, "output strobe after reset");
    for (int i = 0; i < NV; i++)
      do_op(VEC[i][23:21], VEC[i][20:5], VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    // R10 single-cycle pulse: idle cycle after a pulse is low
    do_op(OP_W18, 16'h0002, 1'b0, 10, "program N=2");
    do_op(OP_W19, 16'h0000, 1'b0, 10, "commit auto");
    do_op(OP_INF, 16'h0, 1'b1, 10, "align pulse");
    do_op(OP_IDLE, 16'h0, 1'b0, 10, "no pulse without strobe");
    do_op(OP_OUTF, 16'h0, 1'b0, 10, "output strobe ignored in auto");
    // R1 mid-run reset clears armed one-shot and period
    do_op(OP_W19, 16'h0003, 1'b0, 1, "arm in host mode");
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    do_op(OP_OUTF, 16'h0, 1'b0, 1, "armed cleared by reset");
    do_op(OP_INF, 16'h0, 1'b0, 1, "period cleared by reset");
    do_op(OP_W19, 16'h0000, 1'b0, 1, "commit of cleared hold");
    do_op(OP_INF, 16'h0, 1'b0, 1, "hold cleared by reset");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule